// File: doc/BRIEF.md
# Suspend Modulation Duty-Cycle Generator

This block throttles a processor core by driving an active-low suspend line. While the line is low the core idles with its clock stopped, and while it is high the core runs. Two byte-wide counts set the two phases of a repeating period: a run phase and a suspend phase. Both are measured in a fixed 32 µs tick that a prescaler derives from the system clock. The core's effective speed is its full speed scaled by run/(run + suspend).

Software programs the block through a simple byte-wide register port. Writes are synchronous and reads are combinational. The block holds the two phase counts, a configuration byte whose bit 0 turns modulation on, and a power-management enable byte. That byte has two arm bits, one for interrupt hold-off and one for video hold-off. The block also holds two hold-off reload values, counted in milliseconds.

When an armed interrupt or video event arrives, a hold-off timer loads. While any timer is non-zero, the core runs at full speed. The phase counters keep running underneath, so the pattern resumes in step once the hold-off expires.

Top module: `susmod_gen`

## Requirements
- R1: Six byte registers are mapped: 0x80 power-management enable, 0x8C interrupt hold-off reload, 0x8D video hold-off reload, 0x94 run count, 0x95 suspend count, 0x96 configuration. A write stores the full byte in the following cycle. `reg_rdata` returns the stored byte of the addressed register in the same cycle. Any other address reads 0, and writes to it change nothing.
- R2: A free-running prescaler produces one tick every TICK_DIV clocks. The phase state changes only on a tick.
- R3: With configuration bit 0 set, the pattern repeats as follows. `susp_n` is high for (run count × TICK_DIV) clocks, then low for (suspend count × TICK_DIV) clocks.
- R4: A phase whose count is zero is skipped. If the run count is 0 and the suspend count is non-zero, `susp_n` stays low. If both counts are 0, `susp_n` stays high.
- R5: Both counts are sampled together at the start of each period. A write during a period does not alter the period in progress.
- R6: While configuration bit 0 is clear, `susp_n` is high, starting in the cycle the cleared value is visible. The phase machine returns to idle, and after the bit is set again the first period begins at the next tick.
- R7: If bit 3 of 0x80 is set, an `irq_evt` pulse loads the interrupt hold-off timer from 0x8C. The timer decrements once per millisecond boundary, which is every MS_TICKS ticks. `susp_n` stays high while the timer is non-zero.
- R8: If bit 4 of 0x80 is set, a `vid_evt` pulse loads the video hold-off timer from 0x8D. It behaves the same way as the interrupt hold-off timer.
- R9: An event whose arm bit is clear, or whose reload value is 0, has no effect on `susp_n`.
- R10: An armed event that arrives while its hold-off is active reloads the full value, which extends the hold-off.
- R11: A hold-off does not stop the phase counting. After it ends, `susp_n` follows the pattern that was running underneath.
- R12: After synchronous reset, every register reads 0, the phase machine is idle and `susp_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
The hardest case to reach from the ports is an event that lands while a hold-off is already running. It must coincide with the millisecond boundary and with a suspend phase in progress, since only then does a reload show up as a longer high stretch on `susp_n`. The stimulus uses a small prescaler and a short millisecond divider so that these windows are a few clocks wide. It fires a second armed event partway through a hold-off and rewrites the counts in the middle of a period. A behavioural reference model then compares `susp_n` and `reg_rdata` on every clock, and explicit width measurements confirm the period shapes.

// File: rtl/susmod_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the suspend modulation generator.
// Assumes an 8-bit register address space with byte-wide registers.
package susmod_pkg;

    localparam int AW     = 8;
    localparam int N_SLOT = 6;
    localparam int N_HOLD = 2;

    // storage slot indices
    localparam int S_PMEN = 0;
    localparam int S_IRL  = 1;
    localparam int S_VRL  = 2;
    localparam int S_RUN  = 3;
    localparam int S_SUS  = 4;
    localparam int S_CFG  = 5;

    // field positions decoded by the throttle logic
    localparam int PM_IRQ_BIT = 3;
    localparam int PM_VID_BIT = 4;
    localparam int CFG_EN_BIT = 0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_SUS  = 2'd2
    } phase_e;

    // byte address of each storage slot
    function automatic logic [AW-1:0] slot_addr(input int s);
        logic [AW-1:0] a;
        case (s)
            S_PMEN:  a = 8'h80;
            S_IRL:   a = 8'h8C;
            S_VRL:   a = 8'h8D;
            S_RUN:   a = 8'h94;
            S_SUS:   a = 8'h95;
            default: a = 8'h96;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/susmod_tick.sv
`timescale 1ns/1ps
// Module: susmod_tick
// Free-running prescaler. Emits a one-clock tick every TICK_DIV clocks and a
// one-clock millisecond strobe on every MS_TICKS-th tick.
// Assumes TICK_DIV >= 2 and MS_TICKS >= 1.
module susmod_tick #(
    parameter int TICK_DIV = 8000,
    parameter int MS_TICKS = 31
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic ms_tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int MW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);
    localparam logic [MW-1:0] M_LAST = MW'(MS_TICKS - 1);

    logic [PW-1:0] pcnt;
    logic [MW-1:0] mcnt;

    assign tick    = (pcnt == P_LAST);
    assign ms_tick = tick && (mcnt == M_LAST);

    // clock divider towards the 32 us tick
    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + PW'(1);
    end

    // tick divider towards the millisecond strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       mcnt <= '0;
        else if (ms_tick) mcnt <= '0;
        else if (tick)    mcnt <= mcnt + MW'(1);
    end

endmodule

// File: rtl/susmod_regs.sv
`timescale 1ns/1ps
// Module: susmod_regs
// Byte register file. Writes land on the clock edge and reads are
// combinational. Unmapped addresses read as zero and ignore writes.
// Assumes a single-cycle write strobe from the bus side.
module susmod_regs
    import susmod_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_arm,
    output logic          vid_arm,
    output logic          mod_en,
    output logic [DW-1:0] irq_rl,
    output logic [DW-1:0] vid_rl,
    output logic [DW-1:0] run_cnt,
    output logic [DW-1:0] sus_cnt
);
    logic [N_SLOT-1:0]         hit;
    logic [N_SLOT-1:0][DW-1:0] store;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_dec
        assign hit[s] = (addr == slot_addr(s));
    end

    // register storage with per-slot write enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (we) begin
            for (int s = 0; s < N_SLOT; s++) begin
                if (hit[s]) store[s] <= wdata;
            end
        end
    end

    // read multiplexer, zero for unmapped addresses
    always_comb begin
        rdata = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            if (hit[s]) rdata = rdata | store[s];
        end
    end

    assign irq_arm = store[S_PMEN][PM_IRQ_BIT];
    assign vid_arm = store[S_PMEN][PM_VID_BIT];
    assign mod_en  = store[S_CFG][CFG_EN_BIT];
    assign irq_rl  = store[S_IRL];
    assign vid_rl  = store[S_VRL];
    assign run_cnt = store[S_RUN];
    assign sus_cnt = store[S_SUS];

endmodule

// File: rtl/susmod_phase.sv
`timescale 1ns/1ps
// Module: susmod_phase
// Run/suspend phase sequencer. A period starts with the run phase and is
// followed by the suspend phase. Both counts are sampled at the period start,
// zero-length phases are skipped, and all transitions happen on a tick.
// Disabling returns the sequencer to idle at once.
module susmod_phase
    import susmod_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] run_cnt,
    input  logic [CW-1:0] sus_cnt,
    output phase_e        state
);
    logic [CW-1:0] rem, rem_d;
    logic [CW-1:0] sus_len, sus_len_d;
    phase_e        state_d;
    logic          restart;

    // next-state decision for the phase sequencer
    always_comb begin
        state_d   = state;
        rem_d     = rem;
        sus_len_d = sus_len;
        restart   = 1'b0;
        if (!en) begin
            state_d = PH_IDLE;
            rem_d   = '0;
        end else if (tick) begin
            case (state)
                PH_RUN: begin
                    if (rem > CW'(1)) begin
                        rem_d = rem - CW'(1);
                    end else if (sus_len != '0) begin
                        state_d = PH_SUS;
                        rem_d   = sus_len;
                    end else begin
                        restart = 1'b1;
                    end
                end
                PH_SUS: begin
                    if (rem > CW'(1)) rem_d = rem - CW'(1);
                    else              restart = 1'b1;
                end
                default: restart = 1'b1;
            endcase
            if (restart) begin
                sus_len_d = sus_cnt;
                if (run_cnt != '0) begin
                    state_d = PH_RUN;
                    rem_d   = run_cnt;
                end else if (sus_cnt != '0) begin
                    state_d = PH_SUS;
                    rem_d   = sus_cnt;
                end else begin
                    state_d = PH_IDLE;
                    rem_d   = '0;
                end
            end
        end
    end

    // phase state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_IDLE;
            rem     <= '0;
            sus_len <= '0;
        end else begin
            state   <= state_d;
            rem     <= rem_d;
            sus_len <= sus_len_d;
        end
    end

endmodule

// File: rtl/susmod_hold.sv
`timescale 1ns/1ps
// Module: susmod_hold
// Hold-off timer. An armed event loads the reload value, which takes priority
// over counting. The timer counts down on each millisecond strobe and hold is
// active while it is non-zero. Assumes single-cycle event pulses.
module susmod_hold #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          evt,
    input  logic [TW-1:0] reload,
    input  logic          ms_tick,
    output logic          hold
);
    logic [TW-1:0] cnt;

    assign hold = (cnt != '0);

    // load on armed event, else count down per millisecond
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (evt && arm)        cnt <= reload;
        else if (ms_tick && hold)   cnt <= cnt - TW'(1);
    end

endmodule

// File: rtl/susmod_gen.sv
`timescale 1ns/1ps
// Module: susmod_gen (top)
// Suspend modulation generator. Combines the prescaler, register file, phase
// sequencer and two hold-off timers into the active-low suspend request.
// Assumes event inputs are synchronous single-cycle pulses.
module susmod_gen
    import susmod_pkg::*;
#(
    parameter int TICK_DIV = 8000,
    parameter int MS_TICKS = 31,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          irq_evt,
    input  logic          vid_evt,
    output logic          susp_n
);
    logic          tick;
    logic          ms_tick;
    logic          cfg_en;
    logic [DW-1:0] irq_rl, vid_rl, run_cnt, sus_cnt;
    logic          irq_arm, vid_arm;
    phase_e        ph_state;

    logic [N_HOLD-1:0]         h_evt, h_arm, h_act;
    logic [N_HOLD-1:0][DW-1:0] h_rl;

    susmod_tick #(.TICK_DIV(TICK_DIV), .MS_TICKS(MS_TICKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ms_tick(ms_tick)
    );

    susmod_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .irq_arm(irq_arm), .vid_arm(vid_arm), .mod_en(cfg_en),
        .irq_rl(irq_rl), .vid_rl(vid_rl),
        .run_cnt(run_cnt), .sus_cnt(sus_cnt)
    );

    susmod_phase #(.CW(DW)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .tick(tick),
        .run_cnt(run_cnt), .sus_cnt(sus_cnt), .state(ph_state)
    );

    assign h_evt = {vid_evt, irq_evt};
    assign h_arm = {vid_arm, irq_arm};
    assign h_rl  = {vid_rl, irq_rl};

    for (genvar g = 0; g < N_HOLD; g++) begin : g_hold
        susmod_hold #(.TW(DW)) u_hold (
            .clk(clk), .rst_n(rst_n), .arm(h_arm[g]), .evt(h_evt[g]),
            .reload(h_rl[g]), .ms_tick(ms_tick), .hold(h_act[g])
        );
    end

    // suspend asserted only in the suspend phase, when enabled and not held off
    assign susp_n = !((ph_state == PH_SUS) && cfg_en && !(|h_act));

endmodule

// File: rtl/susmod_chk.sv
`timescale 1ns/1ps
// Module: susmod_chk
// Property checker for susmod_gen, attached with bind below.
module susmod_chk
    import susmod_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        ms_tick,
    input logic        cfg_en,
    input phase_e      ph_state,
    input logic [1:0]  hold_vec,
    input logic        irq_evt,
    input logic        vid_evt,
    input logic        irq_arm,
    input logic        vid_arm,
    input logic        susp_n
);
    // R2: tick never lasts two clocks
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R2: phase only moves on a tick while enabled
    p_state_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_en) && (ph_state != $past(ph_state))) |-> $past(tick));

    // R6: disabled sequencer goes idle
    p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (ph_state == PH_IDLE));

    // R6: no suspend while disabled
    p_out_high_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> susp_n);

    // R9: interrupt hold-off begins only after an armed event
    p_irq_hold_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_vec[0]) |-> $past(irq_evt && irq_arm));

    // R9: video hold-off begins only after an armed event
    p_vid_hold_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_vec[1]) |-> $past(vid_evt && vid_arm));

    // R7: hold-off expires only on a millisecond strobe
    p_hold_end_on_ms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_vec[0]) |-> $past(ms_tick));

    // R8: video hold-off expires only on a millisecond strobe
    p_vid_end_on_ms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_vec[1]) |-> $past(ms_tick));

endmodule

bind susmod_gen susmod_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ms_tick(ms_tick),
    .cfg_en(cfg_en), .ph_state(ph_state), .hold_vec(h_act),
    .irq_evt(irq_evt), .vid_evt(vid_evt),
    .irq_arm(irq_arm), .vid_arm(vid_arm), .susp_n(susp_n)
);

// File: tb/test_susmod_gen.sv
`timescale 1ns/1ps
module test_susmod_gen;
    localparam int DIV = 4;
    localparam int MS  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;

    always #2 clk = ~clk;   // 250 MHz

    susmod_gen #(.TICK_DIV(DIV), .MS_TICKS(MS), .DW(8)) i_susmod_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R12";
    bit    started = 0;
    bit    done = 0;
    int    cyc = 0;

    // reference model state
    logic [7:0] m_pm, m_irl, m_vrl, m_run, m_sus, m_cfg;
    int m_pc, m_mc, m_st, m_rem, m_slen;
    int m_ht [2];
    bit t_now, ms_now, rs;

    task automatic chk(input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_pm = 0; m_irl = 0; m_vrl = 0; m_run = 0; m_sus = 0; m_cfg = 0;
            m_pc = 0; m_mc = 0; m_st = 0; m_rem = 0; m_slen = 0;
            m_ht[0] = 0; m_ht[1] = 0;
        end else begin
            t_now  = (m_pc == DIV - 1);
            ms_now = t_now && (m_mc == MS - 1);
            if (!m_cfg[0]) begin
                m_st = 0; m_rem = 0;
            end else if (t_now) begin
                rs = 0;
                if (m_st == 1) begin
                    if (m_rem > 1) m_rem--;
                    else if (m_slen != 0) begin m_st = 2; m_rem = m_slen; end
                    else rs = 1;
                end else if (m_st == 2) begin
                    if (m_rem > 1) m_rem--; else rs = 1;
                end else rs = 1;
                if (rs) begin
                    m_slen = m_sus;
                    if (m_run != 0)      begin m_st = 1; m_rem = m_run; end
                    else if (m_sus != 0) begin m_st = 2; m_rem = m_sus; end
                    else                 begin m_st = 0; m_rem = 0; end
                end
            end
            if (irq_evt && m_pm[3]) m_ht[0] = m_irl;
            else if (ms_now && m_ht[0] > 0) m_ht[0]--;
            if (vid_evt && m_pm[4]) m_ht[1] = m_vrl;
            else if (ms_now && m_ht[1] > 0) m_ht[1]--;
            if (reg_we) begin
                case (reg_addr)
                    8'h80: m_pm  = reg_wdata;
                    8'h8C: m_irl = reg_wdata;
                    8'h8D: m_vrl = reg_wdata;
                    8'h94: m_run = reg_wdata;
                    8'h95: m_sus = reg_wdata;
                    8'h96: m_cfg = reg_wdata;
                    default: ;
                endcase
            end
            if (ms_now)      m_mc = 0;
            else if (t_now)  m_mc++;
            m_pc = t_now ? 0 : m_pc + 1;
        end
    end

    function automatic logic [7:0] exp_rdata(input logic [7:0] a);
        case (a)
            8'h80: return m_pm;
            8'h8C: return m_irl;
            8'h8D: return m_vrl;
            8'h94: return m_run;
            8'h95: return m_sus;
            8'h96: return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            chk(tag, "susp_n",
                {31'd0, susp_n},
                {31'd0, !(m_st == 2 && m_cfg[0] && m_ht[0] == 0 && m_ht[1] == 0)});
            chk((tag == "R12") ? "R12" : "R1", "reg_rdata",
                {24'd0, reg_rdata}, {24'd0, exp_rdata(reg_addr)});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string r);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(r, "readback", {24'd0, reg_rdata}, {24'd0, e});
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_evt = 1;
        @(negedge clk); irq_evt = 0;
    endtask

    task automatic pulse_vid();
        @(negedge clk); vid_evt = 1;
        @(negedge clk); vid_evt = 0;
    endtask

    // measure one low stretch and the following high stretch of susp_n
    task automatic measure(input int elo, input int ehi, input string r);
        int lo = 0;
        int hi = 0;
        int g  = 0;
        @(negedge clk); #1;
        while (susp_n !== 1'b1 && g < 500) begin @(negedge clk); #1; g++; end
        while (susp_n === 1'b1 && g < 500) begin @(negedge clk); #1; g++; end
        while (susp_n === 1'b0 && g < 500) begin lo++; @(negedge clk); #1; g++; end
        while (susp_n === 1'b1 && g < 500) begin hi++; @(negedge clk); #1; g++; end
        chk(r, "suspend width", lo, elo);
        chk(r, "run width", hi, ehi);
    endtask

    initial begin
        tag = "R12";
        idle(5);
        #1;
        chk("R12", "susp_n in reset", {31'd0, susp_n}, 32'd1);
        rst_n = 1;
        rd(8'h96, 8'h00, "R12");
        rd(8'h80, 8'h00, "R12");
        idle(3);

        // R1: map, readback, unmapped address
        tag = "R1";
        wr(8'h80, 8'hE7); wr(8'h8C, 8'h11); wr(8'h8D, 8'h22);
        wr(8'h94, 8'h33); wr(8'h95, 8'h44); wr(8'h96, 8'hA4);
        wr(8'h81, 8'h5A);
        rd(8'h80, 8'hE7, "R1"); rd(8'h8C, 8'h11, "R1"); rd(8'h8D, 8'h22, "R1");
        rd(8'h94, 8'h33, "R1"); rd(8'h95, 8'h44, "R1"); rd(8'h96, 8'hA4, "R1");
        rd(8'h81, 8'h00, "R1"); rd(8'h00, 8'h00, "R1");
        wr(8'h80, 8'h00); wr(8'h8C, 8'h00); wr(8'h8D, 8'h00);
        wr(8'h94, 8'h00); wr(8'h95, 8'h00); wr(8'h96, 8'h00);

        // R3: basic pattern widths
        tag = "R3";
        wr(8'h94, 8'd3); wr(8'h95, 8'd2); wr(8'h96, 8'h01);
        idle(10);
        measure(2 * DIV, 3 * DIV, "R3");
        idle(20);

        // R2: shortest pattern shows the tick length
        tag = "R2";
        wr(8'h94, 8'd1); wr(8'h95, 8'd1);
        idle(20);
        measure(DIV, DIV, "R2");

        // R5: counts rewritten mid-period
        tag = "R5";
        wr(8'h94, 8'd2); idle(3); wr(8'h95, 8'd6);
        idle(60);
        measure(6 * DIV, 2 * DIV, "R5");

        // R4: zero-count phases
        tag = "R4";
        wr(8'h94, 8'd0); wr(8'h95, 8'd3);
        idle(40); #1;
        chk("R4", "run count 0", {31'd0, susp_n}, 32'd0);
        wr(8'h94, 8'd2); wr(8'h95, 8'd0);
        idle(40); #1;
        chk("R4", "suspend count 0", {31'd0, susp_n}, 32'd1);
        wr(8'h94, 8'd0);
        idle(30); #1;
        chk("R4", "both counts 0", {31'd0, susp_n}, 32'd1);

        // R6: disable in the middle of a suspend phase, then re-enable
        tag = "R6";
        wr(8'h94, 8'd1); wr(8'h95, 8'd8);
        idle(12);
        for (int i = 0; i < 100 && susp_n !== 1'b0; i++) begin @(negedge clk); #1; end
        wr(8'h96, 8'h00);
        #1;
        chk("R6", "disabled output", {31'd0, susp_n}, 32'd1);
        idle(10);
        wr(8'h96, 8'h01);
        idle(40);

        // R7: armed interrupt hold-off
        tag = "R7";
        wr(8'h94, 8'd1); wr(8'h95, 8'd3);
        wr(8'h8C, 8'd2); wr(8'h80, 8'h08);
        idle(20);
        pulse_irq();
        idle(4); #1;
        chk("R7", "held by irq", {31'd0, susp_n}, 32'd1);
        idle(40);

        // R10: re-trigger during an active hold-off
        tag = "R10";
        pulse_irq();
        idle(12);
        pulse_irq();
        idle(4); #1;
        chk("R10", "held after reload", {31'd0, susp_n}, 32'd1);
        idle(40);

        // R8: armed video hold-off
        tag = "R8";
        wr(8'h8D, 8'd3); wr(8'h80, 8'h10);
        pulse_vid();
        idle(4); #1;
        chk("R8", "held by video", {31'd0, susp_n}, 32'd1);
        idle(60);

        // R9: unarmed events and zero reloads are ignored
        tag = "R9";
        wr(8'h80, 8'h00);
        pulse_irq(); pulse_vid();
        begin
            int lows = 0;
            for (int i = 0; i < 24; i++) begin
                @(negedge clk); #1;
                if (susp_n === 1'b0) lows++;
            end
            chk("R9", "suspend seen while unarmed", lows > 0, 1);
        end
        wr(8'h8C, 8'd0); wr(8'h8D, 8'd0); wr(8'h80, 8'h18);
        pulse_irq(); pulse_vid();
        idle(30);

        // R11: pattern continues after a hold-off
        tag = "R11";
        wr(8'h8C, 8'd1); wr(8'h80, 8'h08);
        pulse_irq();
        idle(30);
        measure(3 * DIV, DIV, "R11");

        idle(5);
        finish_run();
    end

endmodule